// File: doc/BRIEF.md
# Ring and Line Reversal Envelope Detector

This block turns a raw call-arrival trigger into a clean, single interrupt-style envelope. The trigger comes from a line front end and goes high on a polarity reversal of the line, or on every half-cycle of a ring burst. The block replaces an external resistor-capacitor stretcher with a digital, retriggerable one-shot. The trigger is synchronized into the clock domain, and each high sample reloads a hold counter from a 24-bit programmable tick count. The active-low envelope stays asserted while the trigger is high and for the programmed number of clocks after the last high sample. A ring burst of about 25 Hz lasting several hundred milliseconds therefore gives one continuous low interval, as long as the hold time covers the gap between ring cycles.

A bypass control turns the stretching off. The envelope then follows the synchronized trigger alone, so firmware can time the ring duration exactly. A one-clock wake pulse marks every high-to-low transition of the envelope and is meant to wake a sleeping controller. The block has no dependency on the rest of the device, so it can stay clocked while other logic is powered down.

Top module: `ring_env_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `env_no` is 1, `wake_o` is 0 and the hold counter is zero.
- R2: The trigger passes through a two-stage synchronizer. A trigger that is high when a rising clock edge samples it drives `env_no` low at the third rising edge, counting that sampling edge as the first.
- R3: Every clock in which the synchronized trigger is high loads the hold counter with `hold_ticks_i`, which is an unsigned count of clock ticks. A value changed between pulses applies to the next pulse. Otherwise a nonzero counter counts down by one per clock.
- R4: With `bypass_i` = 0, a trigger pulse that is high for N clocks gives exactly one low interval of N + `hold_ticks_i` clocks.
- R5: With `bypass_i` = 0, trigger pulses separated by low gaps of at most `hold_ticks_i` clocks are bridged into one continuous low interval. The interval lasts from the first high sample to `hold_ticks_i` clocks after the last high sample.
- R6: With `bypass_i` = 0, a low gap of `hold_ticks_i` + 1 clocks or more releases `env_no` between pulses, so each pulse gives its own low interval.
- R7: With `bypass_i` = 1, `env_no` is the inverse of the synchronized trigger delayed by one clock. A pulse of N clocks gives a low interval of exactly N clocks, whatever the value of `hold_ticks_i`.
- R8: With `bypass_i` = 0 and `hold_ticks_i` = 0, the envelope behaves as in bypass mode: a pulse of N clocks gives N low clocks, and a one-clock gap separates pulses.
- R9: `wake_o` is high for exactly one clock, in the same cycle in which `env_no` first reads low after being high. There is one wake pulse per falling edge of `env_no`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Raw call-arrival trigger, asynchronous, active high |
| hold_ticks_i | input | 24 | Hold time after the last trigger sample, in clock ticks |
| bypass_i | input | 1 | 1 = no stretching; the envelope follows the synchronized trigger |
| env_no | output | 1 | Active-low envelope |
| wake_o | output | 1 | One-clock pulse on each falling edge of `env_no` |

## Verification
The assertions take for granted that reset is asserted from time zero and that `trig_i` has already passed the synchronizer before the hold counter is compared with it. They also take for granted that `bypass_i` and `hold_ticks_i` are treated as values sampled in the cycle in which they are used, so a change between cycles is judged against the value from the previous cycle. The stimulus changes every input only at falling clock edges, keeps `bypass_i` fixed within each scenario, and changes `hold_ticks_i` only in a trigger gap. Hold values stay in the tens of clocks so that gaps just inside and just outside the hold window can both be reached.

// File: rtl/ring_env_pkg.sv
package ring_env_pkg;

    // Registered output stage of the envelope detector
    typedef struct packed {
        logic env_n;   // active-low envelope
        logic wake;    // one-clock falling-edge marker
    } env_out_t;

endpackage

// File: rtl/ring_env_sync.sv
module ring_env_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ring_env_hold.sv
module ring_env_hold #(
    parameter int unsigned HOLD_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_s_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              active_o,
    output logic [HOLD_W-1:0] cnt_o
);
    localparam logic [HOLD_W-1:0] CNT_ONE = HOLD_W'(1);

    typedef struct packed {
        logic [HOLD_W-1:0] cnt;
    } hold_st_t;

    hold_st_t st_d, st_q;

    // Retriggerable one-shot: each trigger sample reloads, else count down
    always_comb begin
        st_d = st_q;
        if (trig_s_i)
            st_d.cnt = hold_i;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CNT_ONE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = trig_s_i | (st_q.cnt != '0);
    assign cnt_o    = st_q.cnt;
endmodule

// File: rtl/ring_env_out.sv
module ring_env_out
    import ring_env_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_s_i,
    input  logic active_i,
    input  logic bypass_i,
    output logic env_no,
    output logic wake_o
);
    env_out_t st_d, st_q;
    logic     low;

    always_comb begin
        low        = bypass_i ? trig_s_i : active_i;
        st_d.env_n = ~low;
        st_d.wake  = st_q.env_n & low;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.env_n <= 1'b1;
            st_q.wake  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign env_no = st_q.env_n;
    assign wake_o = st_q.wake;
endmodule

// File: rtl/ring_env_detector.sv
module ring_env_detector #(
    parameter int unsigned HOLD_W      = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    input  logic [HOLD_W-1:0] hold_ticks_i,
    input  logic              bypass_i,
    output logic              env_no,
    output logic              wake_o
);
    logic              trig_s;
    logic              hold_active;
    logic [HOLD_W-1:0] hold_cnt;

    ring_env_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (trig_i),
        .q_o    (trig_s)
    );

    ring_env_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trig_s_i (trig_s),
        .hold_i   (hold_ticks_i),
        .active_o (hold_active),
        .cnt_o    (hold_cnt)
    );

    ring_env_out u_out (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trig_s_i (trig_s),
        .active_i (hold_active),
        .bypass_i (bypass_i),
        .env_no   (env_no),
        .wake_o   (wake_o)
    );
endmodule

// File: rtl/ring_env_checker.sv
module ring_env_checker #(
    parameter int unsigned HOLD_W = 24
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              trig_s,
    input logic [HOLD_W-1:0] cnt,
    input logic [HOLD_W-1:0] hold_ticks_i,
    input logic              bypass_i,
    input logic              env_no,
    input logic              wake_o
);
    localparam logic [HOLD_W-1:0] CNT_ONE = HOLD_W'(1);

    a_r1_reset_idle: assert property (@(posedge clk_i)
        !rst_ni |=> (env_no && !wake_o && cnt == '0));

    a_r2_trig_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_s |=> !env_no);

    a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_s |=> cnt == $past(hold_ticks_i));

    a_r3_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trig_s && cnt != '0) |=> cnt == $past(cnt) - CNT_ONE);

    a_r4_hold_keeps_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && cnt != '0) |=> !env_no);

    a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bypass_i && !trig_s && cnt == '0) |=> env_no);

    a_r7_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bypass_i |=> env_no == !$past(trig_s));

    a_r9_wake_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |=> !wake_o);

    a_r9_wake_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $fell(env_no));

    a_r9_fall_has_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(env_no) |-> wake_o);
endmodule

bind ring_env_detector ring_env_checker #(.HOLD_W(HOLD_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_s       (trig_s),
    .cnt          (hold_cnt),
    .hold_ticks_i (hold_ticks_i),
    .bypass_i     (bypass_i),
    .env_no       (env_no),
    .wake_o       (wake_o)
);

// File: tb/sim_ring_env_detector.sv
module sim_ring_env_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [23:0] hold = 24'd0;
    logic        bypass = 1'b0;
    logic        env_n;
    logic        wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // monitor results
    int falls = 0;
    int wakes = 0;
    int wake_mis = 0;
    int cur_len = 0;
    int last_len = 0;
    logic prev_env = 1'b1;

    always #2 clk = ~clk;

    ring_env_detector u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .trig_i       (trig),
        .hold_ticks_i (hold),
        .bypass_i     (bypass),
        .env_no       (env_n),
        .wake_o       (wake)
    );

    // Sample 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_env && !env_n) falls++;
            if (wake) wakes++;
            if (wake != (prev_env && !env_n)) wake_mis++;
            if (!env_n) cur_len++;
            else if (!prev_env) begin
                last_len = cur_len;
                cur_len  = 0;
            end
            prev_env = env_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        falls = 0; wakes = 0; wake_mis = 0; last_len = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            trig = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            trig = 1'b1;
            @(negedge clk);
        end
        trig = 1'b0;
    endtask

    task automatic burst(input int k, input int p, input int g);
        for (int i = 0; i < k; i++) begin
            pulse(p);
            if (i != k - 1) idle(g);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 env idle in reset", int'(env_n), 1);
        chk("R1 wake idle in reset", int'(wake), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 env idle after reset", int'(env_n), 1);
        chk("R1 wake idle after reset", int'(wake), 0);
    endtask

    task automatic t_latency();
        bypass = 1'b0; hold = 24'd5; clear_mon();
        trig = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 env high after two edges", int'(env_n), 1);
        @(negedge clk);
        chk("R2 env low at third edge", int'(env_n), 0);
        chk("R9 wake with fall", int'(wake), 1);
        @(negedge clk);
        chk("R9 wake one cycle", int'(wake), 0);
        idle(20);
    endtask

    task automatic t_single();
        bypass = 1'b0; hold = 24'd17; clear_mon();
        pulse(6); idle(40);
        chk("R4 single pulse falls", falls, 1);
        chk("R4 single pulse length", last_len, 6 + 17);
        chk("R9 wake count", wakes, 1);
    endtask

    task automatic t_reload();
        bypass = 1'b0; hold = 24'd10; clear_mon();
        pulse(3); idle(2);
        hold = 24'd40;
        pulse(2); idle(60);
        chk("R3 reload falls", falls, 1);
        chk("R3 reload new hold", last_len, 3 + 2 + 2 + 40);
    endtask

    task automatic t_bridge();
        bypass = 1'b0; hold = 24'd30; clear_mon();
        burst(5, 8, 12); idle(50);
        chk("R5 ring burst one interval", falls, 1);
        chk("R5 ring burst length", last_len, 5 * 8 + 4 * 12 + 30);
        hold = 24'd9; clear_mon();
        burst(3, 4, 9); idle(30);
        chk("R5 gap equal hold bridged", falls, 1);
        chk("R5 gap equal hold length", last_len, 3 * 4 + 2 * 9 + 9);
    endtask

    task automatic t_split();
        bypass = 1'b0; hold = 24'd9; clear_mon();
        burst(3, 4, 10); idle(30);
        chk("R6 gap above hold splits", falls, 3);
        chk("R6 last interval length", last_len, 4 + 9);
        chk("R9 wake per fall", wakes, 3);
    endtask

    task automatic t_bypass();
        bypass = 1'b1; hold = 24'd50; clear_mon();
        pulse(5); idle(10);
        chk("R7 bypass length", last_len, 5);
        chk("R7 bypass falls", falls, 1);
        clear_mon();
        burst(3, 4, 3); idle(10);
        chk("R7 bypass burst falls", falls, 3);
        bypass = 1'b0;
        idle(60);
    endtask

    task automatic t_zero_hold();
        bypass = 1'b0; hold = 24'd0; clear_mon();
        pulse(7); idle(5);
        chk("R8 zero hold length", last_len, 7);
        clear_mon();
        burst(4, 2, 1); idle(5);
        chk("R8 zero hold one-cycle gap splits", falls, 4);
        chk("R9 wake mismatch count", wake_mis, 0);
        chk("R1 env idle when quiet", int'(env_n), 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_single();
        t_reload();
        t_bridge();
        t_split();
        t_bypass();
        t_zero_hold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule